// File: doc/BRIEF.md
# Serial EEPROM Burst Word Reader

This block is a hardware master that fetches a run of consecutive 16-bit words from a three-wire serial configuration EEPROM of the 93C46 kind. The host supplies a starting word address and the number of words minus one, then pulses a start input. The block turns the serial interface on and frames each word as a separate read transaction. For every word it raises chip select, shifts out a three-bit read opcode and a six-bit word address, and then clocks in sixteen data bits. Each finished word appears on the word output with a one-cycle valid strobe.

All pin activity advances in steps of one serial half-period. That half-period is a parameter counted in system clock cycles, and a divider produces the ready tick that paces every step. The address of each word is the start address plus the index of the word in the burst, taken modulo 64. After the last word the interface is switched off and a done pulse ends the busy window.

Top module: `eeprom_burst_reader`

## Requirements
- R1: The interface enable output goes high for one step before the first chip select of a burst and low for the final step after the last word. Chip select is only ever high while enable is high. After done, enable and chip select are both low.
- R2: Each word transaction begins with chip select rising while the serial clock is low. Chip select and a low clock are held for one full step before the first command bit.
- R3: The command starts with the read opcode, binary 110, sent most significant bit first.
- R4: Six address bits follow, most significant bit first. The address is (start address + word index) mod 64, and `word_addr_o` carries that address while the word is reported.
- R5: Each command bit is placed on data-in one step before the clock rises. It stays unchanged through the clock-high step and the following clock-low step. The clock is only high while chip select is high.
- R6: Sixteen data bits are read most significant bit first, each sampled from data-out at the end of a clock-high step. The assembled word appears on `word_data_o` with `word_valid_o` high for exactly one cycle.
- R7: Between two words of a burst, chip select is low for exactly one step and then rises again. A burst of N words has exactly N chip-select pulses.
- R8: A burst returns exactly `words_m1_i + 1` words, from 1 to 64.
- R9: Every step lasts exactly HALF_PERIOD system cycles, so the clock is high for HALF_PERIOD cycles each time. A burst of N words takes HALF_PERIOD*(2+61*N) cycles from the start edge to done.
- R10: `busy_o` is high from the cycle after start is accepted until done. `done_o` is a one-cycle pulse, and busy falls in the same cycle that done rises.
- R11: A start request that arrives while busy has no effect on the running burst, and no second burst follows it.
- R12: During and directly after reset, every output is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begin a burst (accepted only while idle) |
| start_addr_i | input | ADDR_W | First word address |
| words_m1_i | input | ADDR_W | Number of words minus one |
| busy_o | output | 1 | Burst in progress |
| done_o | output | 1 | One-cycle pulse at burst end |
| word_valid_o | output | 1 | One-cycle strobe for a finished word |
| word_data_o | output | DATA_W | Word just read |
| word_addr_o | output | ADDR_W | Address of the word being read |
| ee_en_o | output | 1 | Serial interface enable |
| ee_cs_o | output | 1 | EEPROM chip select |
| ee_sk_o | output | 1 | EEPROM serial clock |
| ee_di_o | output | 1 | Serial data toward the EEPROM |
| ee_do_i | input | 1 | Serial data from the EEPROM |

## Verification
The bench drives a behavioural EEPROM that decodes each command from the pins. That model catches a design with the wrong opcode, bit order or address. It also catches a design that forgets to step the address between words or to wrap it past 63. Bursts at address 62 and a full 64-word burst test the wrap and the longest count; an off-by-one word count shows up as a missing or extra chip-select pulse and word. The bench measures the clock-high length, the gap with chip select low between words, and the total burst length in cycles. A divider or step sequence that is off by one cycle changes all three. A start pulse in the middle of a burst uses a different address and count, so a design that restarts, reloads or queues it returns words from the wrong addresses or an extra burst.

// File: rtl/eerd_pkg.sv
package eerd_pkg;

   typedef enum logic [3:0] {
      ST_IDLE    = 4'd0,
      ST_ENA     = 4'd1,
      ST_CSEL    = 4'd2,
      ST_CMD_SET = 4'd3,
      ST_CMD_HI  = 4'd4,
      ST_CMD_LO  = 4'd5,
      ST_DAT_HI  = 4'd6,
      ST_DAT_LO  = 4'd7,
      ST_CSOFF   = 4'd8,
      ST_DIS     = 4'd9
   } eerd_state_e;

   typedef struct packed {
      logic en;
      logic cs;
      logic sk;
      logic di;
   } eerd_pins_t;

   function automatic int unsigned eerd_max(input int unsigned a, input int unsigned b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/eerd_tick_gen.sv
module eerd_tick_gen #(
   parameter int unsigned HALF_PERIOD = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run_i,
   output logic tick_o
);

   generate
      if (HALF_PERIOD == 1) begin : g_every_cycle
         assign tick_o = run_i;
      end else begin : g_divider
         localparam int unsigned CNT_W = $clog2(HALF_PERIOD);
         localparam logic [CNT_W-1:0] LAST = CNT_W'(HALF_PERIOD - 1);
         logic [CNT_W-1:0] cnt_q;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               cnt_q <= '0;
            end else if (!run_i || cnt_q == LAST) begin
               cnt_q <= '0;
            end else begin
               cnt_q <= cnt_q + 1'b1;
            end
         end

         assign tick_o = run_i && (cnt_q == LAST);
      end
   endgenerate

endmodule

// File: rtl/eerd_cmd_mux.sv
module eerd_cmd_mux #(
   parameter int unsigned OPC_W  = 3,
   parameter int unsigned ADDR_W = 6,
   parameter int unsigned BIT_W  = 4,
   parameter logic [OPC_W-1:0] OPCODE = 3'b110
) (
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [BIT_W-1:0]  idx_i,
   output logic              bit_o
);

   localparam int unsigned CMD_W = OPC_W + ADDR_W;
   localparam int unsigned SLOTS = 2 ** BIT_W;

   logic [CMD_W-1:0] cmd;
   logic [SLOTS-1:0] order;

   assign cmd = {OPCODE, addr_i};

   // order[k] is the k-th bit on the wire: MSB of the command first
   generate
      for (genvar g = 0; g < SLOTS; g++) begin : g_slot
         if (g < CMD_W) begin : g_used
            assign order[g] = cmd[CMD_W-1-g];
         end else begin : g_pad
            assign order[g] = 1'b0;
         end
      end
   endgenerate

   assign bit_o = order[idx_i];

endmodule

// File: rtl/eerd_rx_shift.sv
module eerd_rx_shift #(
   parameter int unsigned DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              shift_i,
   input  logic              bit_i,
   output logic [DATA_W-1:0] data_o
);

   logic [DATA_W-1:0] sr_q;

   // MSB arrives first, so each new bit enters at the bottom
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sr_q <= '0;
      end else if (shift_i) begin
         sr_q <= {sr_q[DATA_W-2:0], bit_i};
      end
   end

   assign data_o = sr_q;

endmodule

// File: rtl/eerd_seq.sv
module eerd_seq
   import eerd_pkg::*;
#(
   parameter int unsigned ADDR_W = 6,
   parameter int unsigned CMD_W  = 9,
   parameter int unsigned DATA_W = 16,
   parameter int unsigned BIT_W  = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [ADDR_W-1:0] words_m1_i,
   input  logic              tick_i,
   output eerd_state_e       state_o,
   output logic [BIT_W-1:0]  bit_idx_o,
   output logic [ADDR_W-1:0] addr_o,
   output logic              sample_o,
   output logic              valid_o,
   output logic              done_o
);

   localparam logic [BIT_W-1:0] CMD_LAST = BIT_W'(CMD_W - 1);
   localparam logic [BIT_W-1:0] DAT_LAST = BIT_W'(DATA_W - 1);

   eerd_state_e       state_q;
   logic [BIT_W-1:0]  bit_q;
   logic [ADDR_W-1:0] addr_q;
   logic [ADDR_W-1:0] left_q;
   logic              valid_q;
   logic              done_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         bit_q   <= '0;
         addr_q  <= '0;
         left_q  <= '0;
         valid_q <= 1'b0;
         done_q  <= 1'b0;
      end else begin
         valid_q <= 1'b0;
         done_q  <= 1'b0;
         if (state_q == ST_IDLE) begin
            if (start_i) begin
               state_q <= ST_ENA;
               addr_q  <= addr_i;
               left_q  <= words_m1_i;
               bit_q   <= '0;
            end
         end else if (tick_i) begin
            unique case (state_q)
               ST_ENA:     state_q <= ST_CSEL;
               ST_CSEL: begin
                  state_q <= ST_CMD_SET;
                  bit_q   <= '0;
               end
               ST_CMD_SET: state_q <= ST_CMD_HI;
               ST_CMD_HI:  state_q <= ST_CMD_LO;
               ST_CMD_LO: begin
                  if (bit_q == CMD_LAST) begin
                     state_q <= ST_DAT_HI;
                     bit_q   <= '0;
                  end else begin
                     state_q <= ST_CMD_SET;
                     bit_q   <= bit_q + 1'b1;
                  end
               end
               ST_DAT_HI:  state_q <= ST_DAT_LO;
               ST_DAT_LO: begin
                  if (bit_q == DAT_LAST) begin
                     state_q <= ST_CSOFF;
                     valid_q <= 1'b1;
                  end else begin
                     state_q <= ST_DAT_HI;
                     bit_q   <= bit_q + 1'b1;
                  end
               end
               ST_CSOFF: begin
                  if (left_q == '0) begin
                     state_q <= ST_DIS;
                  end else begin
                     state_q <= ST_CSEL;
                     left_q  <= left_q - 1'b1;
                     addr_q  <= addr_q + 1'b1;
                  end
               end
               ST_DIS: begin
                  state_q <= ST_IDLE;
                  done_q  <= 1'b1;
               end
               default:    state_q <= ST_IDLE;
            endcase
         end
      end
   end

   assign state_o   = state_q;
   assign bit_idx_o = bit_q;
   assign addr_o    = addr_q;
   assign sample_o  = tick_i && (state_q == ST_DAT_HI);
   assign valid_o   = valid_q;
   assign done_o    = done_q;

endmodule

// File: rtl/eeprom_burst_reader.sv
module eeprom_burst_reader
   import eerd_pkg::*;
#(
   parameter int unsigned HALF_PERIOD = 4,
   parameter int unsigned ADDR_W      = 6,
   parameter int unsigned DATA_W      = 16,
   parameter int unsigned OPC_W       = 3,
   parameter logic [OPC_W-1:0] OPCODE = 3'b110
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic [ADDR_W-1:0] start_addr_i,
   input  logic [ADDR_W-1:0] words_m1_i,
   output logic              busy_o,
   output logic              done_o,
   output logic              word_valid_o,
   output logic [DATA_W-1:0] word_data_o,
   output logic [ADDR_W-1:0] word_addr_o,
   output logic              ee_en_o,
   output logic              ee_cs_o,
   output logic              ee_sk_o,
   output logic              ee_di_o,
   input  logic              ee_do_i
);

   localparam int unsigned CMD_W = OPC_W + ADDR_W;
   localparam int unsigned BIT_W = $clog2(eerd_max(CMD_W, DATA_W));

   generate
      if (HALF_PERIOD < 1 || HALF_PERIOD > 65535) begin : g_bad_half
         $error("HALF_PERIOD must lie in 1..65535");
      end
      if (ADDR_W < 1 || DATA_W < 2 || OPC_W < 1) begin : g_bad_width
         $error("ADDR_W, DATA_W and OPC_W are too small");
      end
   endgenerate

   eerd_state_e       state;
   logic [BIT_W-1:0]  bit_idx;
   logic [ADDR_W-1:0] cur_addr;
   logic              tick;
   logic              sample;
   logic              cmd_bit;
   eerd_pins_t        pins;

   assign busy_o = (state != ST_IDLE);

   eerd_tick_gen #(
      .HALF_PERIOD (HALF_PERIOD)
   ) u_tick (
      .clk    (clk),
      .rst_n  (rst_n),
      .run_i  (busy_o),
      .tick_o (tick)
   );

   eerd_seq #(
      .ADDR_W (ADDR_W),
      .CMD_W  (CMD_W),
      .DATA_W (DATA_W),
      .BIT_W  (BIT_W)
   ) u_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .start_i    (start_i),
      .addr_i     (start_addr_i),
      .words_m1_i (words_m1_i),
      .tick_i     (tick),
      .state_o    (state),
      .bit_idx_o  (bit_idx),
      .addr_o     (cur_addr),
      .sample_o   (sample),
      .valid_o    (word_valid_o),
      .done_o     (done_o)
   );

   eerd_cmd_mux #(
      .OPC_W  (OPC_W),
      .ADDR_W (ADDR_W),
      .BIT_W  (BIT_W),
      .OPCODE (OPCODE)
   ) u_cmd (
      .addr_i (cur_addr),
      .idx_i  (bit_idx),
      .bit_o  (cmd_bit)
   );

   eerd_rx_shift #(
      .DATA_W (DATA_W)
   ) u_rx (
      .clk     (clk),
      .rst_n   (rst_n),
      .shift_i (sample),
      .bit_i   (ee_do_i),
      .data_o  (word_data_o)
   );

   always_comb begin
      pins = '0;
      unique case (state)
         ST_ENA, ST_CSOFF:      pins.en = 1'b1;
         ST_CSEL, ST_DAT_LO: begin
            pins.en = 1'b1;
            pins.cs = 1'b1;
         end
         ST_DAT_HI: begin
            pins.en = 1'b1;
            pins.cs = 1'b1;
            pins.sk = 1'b1;
         end
         ST_CMD_SET, ST_CMD_LO: begin
            pins.en = 1'b1;
            pins.cs = 1'b1;
            pins.di = cmd_bit;
         end
         ST_CMD_HI: begin
            pins.en = 1'b1;
            pins.cs = 1'b1;
            pins.sk = 1'b1;
            pins.di = cmd_bit;
         end
         default:               pins = '0;
      endcase
   end

   assign word_addr_o = cur_addr;
   assign ee_en_o     = pins.en;
   assign ee_cs_o     = pins.cs;
   assign ee_sk_o     = pins.sk;
   assign ee_di_o     = pins.di;

endmodule

// File: rtl/eerd_checker.sv
module eerd_checker #(
   parameter int unsigned HALF_PERIOD = 4,
   parameter int unsigned ADDR_W      = 6
) (
   input logic              clk,
   input logic              rst_n,
   input logic              busy_o,
   input logic              done_o,
   input logic              word_valid_o,
   input logic [ADDR_W-1:0] word_addr_o,
   input logic              ee_en_o,
   input logic              ee_cs_o,
   input logic              ee_sk_o,
   input logic              ee_di_o
);

   logic [15:0] hi_len;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hi_len <= '0;
      end else if (ee_sk_o) begin
         if (hi_len != 16'hFFFF) hi_len <= hi_len + 1'b1;
      end else begin
         hi_len <= '0;
      end
   end

   AST_CS_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
      ee_cs_o |-> ee_en_o); // R1
   AST_CS_RISE_SK_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ee_cs_o) |-> !ee_sk_o); // R2
   AST_SK_INSIDE_CS: assert property (@(posedge clk) disable iff (!rst_n)
      ee_sk_o |-> ee_cs_o); // R5
   AST_DI_HELD_SK_HI: assert property (@(posedge clk) disable iff (!rst_n)
      (ee_sk_o && $past(ee_sk_o)) |-> $stable(ee_di_o)); // R5
   AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && $past(busy_o) && (word_addr_o != $past(word_addr_o)))
         |-> (word_addr_o == ADDR_W'($past(word_addr_o) + 1'b1))); // R4
   AST_VALID_IN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      word_valid_o |-> busy_o); // R6
   AST_DONE_ENDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy_o) |-> done_o); // R10
   AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> (!busy_o && !ee_en_o)); // R10
   AST_SK_HALF_LEN: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(ee_sk_o) |-> (hi_len == 16'(HALF_PERIOD))); // R9

endmodule

bind eeprom_burst_reader eerd_checker #(
   .HALF_PERIOD (HALF_PERIOD),
   .ADDR_W      (ADDR_W)
) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .busy_o       (busy_o),
   .done_o       (done_o),
   .word_valid_o (word_valid_o),
   .word_addr_o  (word_addr_o),
   .ee_en_o      (ee_en_o),
   .ee_cs_o      (ee_cs_o),
   .ee_sk_o      (ee_sk_o),
   .ee_di_o      (ee_di_o)
);

// File: tb/eeprom_burst_reader_tb.sv
module eeprom_burst_reader_tb;

   localparam int HALF = 4;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [5:0]  start_addr = '0;
   logic [5:0]  words_m1 = '0;
   logic        busy_o, done_o, word_valid_o;
   logic [15:0] word_data_o;
   logic [5:0]  word_addr_o;
   logic        ee_en_o, ee_cs_o, ee_sk_o, ee_di_o;
   logic        ee_do = 1'b0;

   always #10 clk = ~clk;

   eeprom_burst_reader u_dut (
      .clk          (clk),
      .rst_n        (rst_n),
      .start_i      (start),
      .start_addr_i (start_addr),
      .words_m1_i   (words_m1),
      .busy_o       (busy_o),
      .done_o       (done_o),
      .word_valid_o (word_valid_o),
      .word_data_o  (word_data_o),
      .word_addr_o  (word_addr_o),
      .ee_en_o      (ee_en_o),
      .ee_cs_o      (ee_cs_o),
      .ee_sk_o      (ee_sk_o),
      .ee_di_o      (ee_di_o),
      .ee_do_i      (ee_do)
   );

   int checks = 0;
   int errors = 0;
   logic [15:0] mem [64];

   int exp_base = 0, words_seen = 0, cs_rises = 0;
   int sk_hi = 0, cs_lo = 0, en_hi = 0;
   int cmd_cnt = 0, dk = 0;
   logic [8:0]  cmd_sr = '0;
   logic [15:0] cur = '0;
   logic prev_sk = 0, prev_cs = 0, prev_di = 0, di_at_rise = 0;

   task automatic chk(input bit ok, input string req, input string what,
                      input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   function automatic int addr_of(input int base, input int idx);
      return (base + idx) % 64;
   endfunction

   function automatic int burst_cycles(input int n);
      return HALF * (2 + 61 * n);
   endfunction

   // Pin monitor and behavioural EEPROM
   always @(negedge clk) begin
      if (rst_n) begin
         if (ee_cs_o && !prev_cs) begin
            cs_rises++;
            chk(!ee_sk_o, "R2", "clock at chip select rise", ee_sk_o, 0);
            chk(ee_en_o && en_hi >= HALF, "R1", "enable lead before chip select", en_hi, HALF);
            if (cs_rises > 1) chk(cs_lo == HALF, "R7", "chip select gap", cs_lo, HALF);
            cmd_cnt = 0;
         end
         if (ee_sk_o && !prev_sk) begin
            sk_hi = 1;
            di_at_rise = ee_di_o;
            if (cmd_cnt < 9) begin
               chk(ee_di_o == prev_di, "R5", "data-in set before clock rise", ee_di_o, prev_di);
               cmd_sr = {cmd_sr[7:0], ee_di_o};
               cmd_cnt++;
               if (cmd_cnt == 9) begin
                  chk(cmd_sr[8:6] == 3'b110, "R3", "opcode", cmd_sr[8:6], 3'b110);
                  chk(int'(cmd_sr[5:0]) == addr_of(exp_base, words_seen), "R4", "address sent",
                      cmd_sr[5:0], addr_of(exp_base, words_seen));
                  cur = mem[cmd_sr[5:0]];
                  dk = 0;
               end
            end else if (dk < 16) begin
               ee_do = cur[15-dk];
               dk++;
            end
         end else if (ee_sk_o) begin
            sk_hi++;
         end
         if (!ee_sk_o && prev_sk) begin
            chk(sk_hi == HALF, "R9", "clock high length", sk_hi, HALF);
            chk(ee_di_o == di_at_rise, "R5", "data-in held through clock pulse", ee_di_o, di_at_rise);
         end
         if (word_valid_o) begin
            chk(int'(word_addr_o) == addr_of(exp_base, words_seen), "R4", "reported address",
                word_addr_o, addr_of(exp_base, words_seen));
            chk(word_data_o == mem[addr_of(exp_base, words_seen)], "R6", "word data",
                word_data_o, mem[addr_of(exp_base, words_seen)]);
            words_seen++;
         end
         if (!ee_cs_o) cs_lo++; else cs_lo = 0;
         if (ee_en_o) en_hi++; else en_hi = 0;
         prev_sk = ee_sk_o;
         prev_cs = ee_cs_o;
         prev_di = ee_di_o;
      end
   end

   task automatic run_burst(input int base, input int n, input bit poke);
      int  cyc;
      bit  saw_done;
      exp_base   = base;
      words_seen = 0;
      cs_rises   = 0;
      cs_lo      = 0;
      en_hi      = 0;
      @(negedge clk);
      start_addr = 6'(base);
      words_m1   = 6'(n - 1);
      start      = 1'b1;
      @(negedge clk);
      start = 1'b0;
      chk(busy_o, "R10", "busy after start", busy_o, 1);
      cyc = 0;
      saw_done = 0;
      while (!saw_done && cyc < 20000) begin
         if (poke && cyc == 300) begin
            start      = 1'b1;
            start_addr = 6'(base) ^ 6'h2a;
            words_m1   = 6'd40;
         end else begin
            start = 1'b0;
         end
         @(negedge clk);
         cyc++;
         if (done_o) saw_done = 1;
      end
      start = 1'b0;
      chk(saw_done, "R10", "done seen", saw_done, 1);
      chk(cyc == burst_cycles(n), "R9", "burst length in cycles", cyc, burst_cycles(n));
      chk(!busy_o, "R10", "busy low with done", busy_o, 0);
      chk(words_seen == n, "R8", "word count", words_seen, n);
      chk(cs_rises == n, "R7", "chip select pulses", cs_rises, n);
      chk(!ee_en_o && !ee_cs_o, "R1", "interface off after done", {ee_en_o, ee_cs_o}, 0);
      @(negedge clk);
      chk(!done_o, "R10", "done is one cycle", done_o, 0);
      repeat (3) @(negedge clk);
      chk(!busy_o, "R11", "no burst after ignored start", busy_o, 0);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog: actual=expired expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      void'($urandom(32'd4711));
      for (int i = 0; i < 64; i++) mem[i] = 16'($urandom);
      mem[0]  = 16'hFFFF;
      mem[63] = 16'h8001;
      mem[1]  = 16'h0000;

      repeat (3) @(negedge clk);
      chk({busy_o, done_o, word_valid_o, ee_en_o, ee_cs_o, ee_sk_o, ee_di_o} == '0,
          "R12", "outputs in reset",
          {busy_o, done_o, word_valid_o, ee_en_o, ee_cs_o, ee_sk_o, ee_di_o}, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk({busy_o, done_o, word_valid_o, ee_en_o, ee_cs_o, ee_sk_o} == '0,
          "R12", "outputs after reset",
          {busy_o, done_o, word_valid_o, ee_en_o, ee_cs_o, ee_sk_o}, 0);

      run_burst(0, 1, 0);    // single word, all-ones data
      run_burst(62, 4, 0);   // address wrap 62,63,0,1
      run_burst(5, 3, 1);    // start pulse while busy (R11)
      run_burst(17, 64, 0);  // full burst
      for (int k = 0; k < 6; k++) begin
         run_burst(int'($urandom % 64), 1 + int'($urandom % 8), 0);
      end

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule